// File: doc/BRIEF.md
# AXI4-Lite Address Decoder with Error Responder

This block sits at the front of an AXI4-Lite fabric and decides which target each read and each write address belongs to. Reads and writes are looked up in two independent maps. Both maps are built from one shared table of address regions. Each slave also carries a two-bit access policy. A region whose slave does not permit a direction simply drops out of that direction's map. As a result, a read-only slave cannot be reached by a write, and a write-only slave cannot be reached by a read. Several disjoint regions may point at the same slave.

Any address that lands in a hole, or in a region whose slave forbids the direction, is routed to a designated error slave index. A small built-in error target answers those transactions. For a read it returns zero data with a DECERR response. For a write it takes the address and the write beat in either order and then returns DECERR. Arbitration among masters and data multiplexing towards the real slaves are left to the surrounding fabric. That fabric steers write-data beats destined for the error slave onto the error target's W input.

Top module: `axil_addr_router`

## Requirements
- R1: `rd_sel` is registered: one clock after `ar_addr` is presented, it holds the read-map slave index. A region matches when base <= addr < bound. When regions overlap, the lowest-numbered region wins.
- R2: `wr_sel` is registered in the same way from `aw_addr`, using the write map.
- R3: Policy encoding is bit 0 = readable and bit 1 = writable (00 error, 01 read-only, 10 write-only, 11 read-write). An address in a region whose slave lacks the needed bit selects the error index: a read of a write-only slave, or a write of a read-only slave.
- R4: An address matching no region selects the error index (`ERR_IDX`, default 0) in both maps.
- R5: Two disjoint regions that name the same slave both select that slave.
- R6: `ar_ready` is high exactly when `ar_addr` currently decodes to the error index and no read response is pending.
- R7: One clock after an accepted read, `r_valid` rises with `r_data` = 0 and `r_resp` = 2'b11. Both are held until the clock in which `r_ready` is high.
- R8: The error target accepts AW and W in either order or together. `b_valid` with `b_resp` = 2'b11 rises on the clock after the second of the two is accepted, and is held until `b_ready`.
- R9: While a write response is pending, `aw_ready` and `ew_ready` are low. Each half of a write is also refused once it has been taken, until the response is sent. `aw_ready` additionally requires that `aw_addr` decodes to the error index.
- R10: After reset, `r_valid` and `b_valid` are low, and `rd_sel` and `wr_sel` equal the error index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ar_valid | input | 1 | Read address valid |
| ar_addr | input | ADDR_W | Read address |
| ar_ready | output | 1 | Error target accepts the read address |
| rd_sel | output | SEL_W | Registered read slave index |
| aw_valid | input | 1 | Write address valid |
| aw_addr | input | ADDR_W | Write address |
| aw_ready | output | 1 | Error target accepts the write address |
| wr_sel | output | SEL_W | Registered write slave index |
| ew_valid | input | 1 | Write beat steered to the error target |
| ew_ready | output | 1 | Error target accepts the write beat |
| b_valid | output | 1 | Write response valid |
| b_resp | output | 2 | Write response code |
| b_ready | input | 1 | Write response taken |
| r_valid | output | 1 | Read response valid |
| r_data | output | DATA_W | Read data, always zero |
| r_resp | output | 2 | Read response code |
| r_ready | input | 1 | Read response taken |

## Verification
The bench probes each region edge (base, bound − 1 and bound), the holes between regions, the disjoint pair that shares a slave, and the regions whose policy forbids one direction. A decoder with an inclusive bound, a reversed priority or a missing policy mask would show a wrong index there. Writes are driven with the address first, with the data first, and with both together, and responses are held back. An error target that needs a fixed order, drops a half taken early, or lets a response fall without its ready would then miss or duplicate a response. Further long stretches mix random traffic with the back-pressure, which exposes any acceptance while a response is pending.

// File: rtl/axil_dec_pkg.sv
package axil_dec_pkg;
  localparam logic [1:0] RESP_DECERR = 2'b11;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam int POL_RD_BIT = 0;
  localparam int POL_WR_BIT = 1;
endpackage

// File: rtl/axil_map_lookup.sv
module axil_map_lookup #(
  parameter int ADDR_W  = 16,
  parameter int N_SLV   = 4,
  parameter int N_REG   = 4,
  parameter int SEL_W   = 2,
  parameter int ERR_IDX = 0,
  parameter int DIR_BIT = 0,
  parameter logic [N_REG*ADDR_W-1:0] REG_BASE  = '0,
  parameter logic [N_REG*ADDR_W-1:0] REG_BOUND = '0,
  parameter logic [N_REG*8-1:0]      REG_TGT   = '0,
  parameter logic [N_SLV*2-1:0]      SLV_POL   = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SEL_W-1:0]  sel
);
  logic [N_REG-1:0] hit;

  generate
    for (genvar g = 0; g < N_REG; g++) begin : g_reg
      logic [ADDR_W-1:0] lo_w, hi_w;
      assign lo_w   = REG_BASE[g*ADDR_W +: ADDR_W];
      assign hi_w   = REG_BOUND[g*ADDR_W +: ADDR_W];
      assign hit[g] = !(addr < lo_w) && (addr < hi_w);
    end
  endgenerate

  logic [7:0] tgt;
  logic       any_hit;
  logic       allowed;

  always_comb begin
    tgt     = '0;
    any_hit = 1'b0;
    for (int i = N_REG - 1; i >= 0; i--) begin
      if (hit[i]) begin
        tgt     = REG_TGT[i*8 +: 8];
        any_hit = 1'b1;
      end
    end
    allowed = 1'b0;
    for (int s = 0; s < N_SLV; s++) begin
      if (int'(tgt) == s) allowed = SLV_POL[s*2 + DIR_BIT];
    end
    sel = SEL_W'(ERR_IDX);
    if (any_hit && allowed) sel = tgt[SEL_W-1:0];
  end
endmodule

// File: rtl/axil_err_rd_target.sv
module axil_err_rd_target
  import axil_dec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ar_valid,
  input  logic              route_err,
  output logic              ar_ready,
  output logic              r_valid,
  output logic [DATA_W-1:0] r_data,
  output logic [1:0]        r_resp,
  input  logic              r_ready
);
  assign ar_ready = route_err && !r_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_valid <= 1'b0;
      r_resp  <= RESP_OKAY;
    end else if (ar_valid && ar_ready) begin
      r_valid <= 1'b1;
      r_resp  <= RESP_DECERR;
    end else if (r_valid && r_ready) begin
      r_valid <= 1'b0;
      r_resp  <= RESP_OKAY;
    end
  end

  assign r_data = '0;
endmodule

// File: rtl/axil_err_wr_target.sv
module axil_err_wr_target
  import axil_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       aw_valid,
  input  logic       route_err,
  output logic       aw_ready,
  input  logic       w_valid,
  output logic       w_ready,
  output logic       b_valid,
  output logic [1:0] b_resp,
  input  logic       b_ready
);
  logic aw_taken, w_taken;
  logic aw_have, w_have;

  assign aw_ready = route_err && !aw_taken && !b_valid;
  assign w_ready  = !w_taken && !b_valid;
  assign aw_have  = aw_taken || (aw_valid && aw_ready);
  assign w_have   = w_taken  || (w_valid && w_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_taken <= 1'b0;
      w_taken  <= 1'b0;
      b_valid  <= 1'b0;
      b_resp   <= RESP_OKAY;
    end else if (aw_have && w_have) begin
      aw_taken <= 1'b0;
      w_taken  <= 1'b0;
      b_valid  <= 1'b1;
      b_resp   <= RESP_DECERR;
    end else begin
      aw_taken <= aw_have;
      w_taken  <= w_have;
      if (b_valid && b_ready) begin
        b_valid <= 1'b0;
        b_resp  <= RESP_OKAY;
      end
    end
  end
endmodule

// File: rtl/axil_addr_router.sv
module axil_addr_router
  import axil_dec_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int N_SLV   = 4,
  parameter int N_REG   = 4,
  parameter int SEL_W   = (N_SLV > 1) ? $clog2(N_SLV) : 1,
  parameter int ERR_IDX = 0,
  parameter logic [N_REG*ADDR_W-1:0] REG_BASE  = {16'h2000, 16'h8000, 16'h1000, 16'h0000},
  parameter logic [N_REG*ADDR_W-1:0] REG_BOUND = {16'h3000, 16'h9000, 16'h2000, 16'h1000},
  parameter logic [N_REG*8-1:0]      REG_TGT   = {8'd3, 8'd1, 8'd2, 8'd1},
  parameter logic [N_SLV*2-1:0]      SLV_POL   = {2'b10, 2'b01, 2'b11, 2'b00}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ar_valid,
  input  logic [ADDR_W-1:0] ar_addr,
  output logic              ar_ready,
  output logic [SEL_W-1:0]  rd_sel,
  input  logic              aw_valid,
  input  logic [ADDR_W-1:0] aw_addr,
  output logic              aw_ready,
  output logic [SEL_W-1:0]  wr_sel,
  input  logic              ew_valid,
  output logic              ew_ready,
  output logic              b_valid,
  output logic [1:0]        b_resp,
  input  logic              b_ready,
  output logic              r_valid,
  output logic [DATA_W-1:0] r_data,
  output logic [1:0]        r_resp,
  input  logic              r_ready
);
  localparam logic [SEL_W-1:0] ERR_SEL = SEL_W'(ERR_IDX);

  logic [SEL_W-1:0] rd_dec, wr_dec;

  axil_map_lookup #(
    .ADDR_W(ADDR_W), .N_SLV(N_SLV), .N_REG(N_REG), .SEL_W(SEL_W),
    .ERR_IDX(ERR_IDX), .DIR_BIT(POL_RD_BIT),
    .REG_BASE(REG_BASE), .REG_BOUND(REG_BOUND), .REG_TGT(REG_TGT), .SLV_POL(SLV_POL)
  ) u_rd_map (.addr(ar_addr), .sel(rd_dec));

  axil_map_lookup #(
    .ADDR_W(ADDR_W), .N_SLV(N_SLV), .N_REG(N_REG), .SEL_W(SEL_W),
    .ERR_IDX(ERR_IDX), .DIR_BIT(POL_WR_BIT),
    .REG_BASE(REG_BASE), .REG_BOUND(REG_BOUND), .REG_TGT(REG_TGT), .SLV_POL(SLV_POL)
  ) u_wr_map (.addr(aw_addr), .sel(wr_dec));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sel <= ERR_SEL;
      wr_sel <= ERR_SEL;
    end else begin
      rd_sel <= rd_dec;
      wr_sel <= wr_dec;
    end
  end

  axil_err_rd_target #(.DATA_W(DATA_W)) u_err_rd (
    .clk(clk), .rst(rst), .ar_valid(ar_valid), .route_err(rd_dec == ERR_SEL),
    .ar_ready(ar_ready), .r_valid(r_valid), .r_data(r_data), .r_resp(r_resp),
    .r_ready(r_ready)
  );

  axil_err_wr_target u_err_wr (
    .clk(clk), .rst(rst), .aw_valid(aw_valid), .route_err(wr_dec == ERR_SEL),
    .aw_ready(aw_ready), .w_valid(ew_valid), .w_ready(ew_ready),
    .b_valid(b_valid), .b_resp(b_resp), .b_ready(b_ready)
  );
endmodule

// File: rtl/axil_addr_router_chk.sv
module axil_addr_router_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic              aw_valid,
  input logic              aw_ready,
  input logic              ew_valid,
  input logic              ew_ready,
  input logic              b_valid,
  input logic [1:0]        b_resp,
  input logic              b_ready,
  input logic              r_valid,
  input logic [DATA_W-1:0] r_data,
  input logic [1:0]        r_resp,
  input logic              r_ready
);
  assert_rd_launch_R7: assert property (@(posedge clk) disable iff (rst)
    (ar_valid && ar_ready) |=> r_valid);
  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (r_valid && !r_ready) |=> r_valid);
  assert_rd_code_R7: assert property (@(posedge clk) disable iff (rst)
    r_valid |-> (r_resp == 2'b11 && r_data == '0));
  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (b_valid && !b_ready) |=> b_valid);
  assert_wr_code_R8: assert property (@(posedge clk) disable iff (rst)
    b_valid |-> b_resp == 2'b11);
  assert_wr_pair_R8: assert property (@(posedge clk) disable iff (rst)
    (aw_valid && aw_ready && ew_valid && ew_ready) |=> b_valid);
  assert_rd_block_R6: assert property (@(posedge clk) disable iff (rst)
    r_valid |-> !ar_ready);
  assert_wr_block_R9: assert property (@(posedge clk) disable iff (rst)
    b_valid |-> (!aw_ready && !ew_ready));
endmodule

bind axil_addr_router axil_addr_router_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/axil_addr_router_tb_top.sv
`timescale 1ns/1ps
module axil_addr_router_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          ar_valid = 0, aw_valid = 0, ew_valid = 0, b_ready = 0, r_ready = 0;
  logic [AW-1:0] ar_addr = '0, aw_addr = '0;
  logic          ar_ready, aw_ready, ew_ready, b_valid, r_valid;
  logic [1:0]    rd_sel, wr_sel, b_resp, r_resp;
  logic [DW-1:0] r_data;

  axil_addr_router dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0;
  bit done = 0;

  // Reference maps: slave1 RW at 0x0000-0x0FFF and 0x8000-0x8FFF (R5),
  // slave2 read-only 0x1000-0x1FFF, slave3 write-only 0x2000-0x2FFF (R3),
  // everything else a hole -> index 0 (R4).
  function automatic int ref_rd(input logic [AW-1:0] a);
    if (a < 16'h1000) return 1;
    if (a < 16'h2000) return 2;
    if (a >= 16'h8000 && a < 16'h9000) return 1;
    return 0;
  endfunction
  function automatic int ref_wr(input logic [AW-1:0] a);
    if (a < 16'h1000) return 1;
    if (a >= 16'h2000 && a < 16'h3000) return 3;
    if (a >= 16'h8000 && a < 16'h9000) return 1;
    return 0;
  endfunction

  int m_rsel = 0, m_wsel = 0;
  bit m_rv = 0, m_bv = 0, m_awgot = 0, m_wgot = 0;
  bit e_arr, e_awr, e_wr;
  always_comb begin
    e_arr = (ref_rd(ar_addr) == 0) && !m_rv;
    e_awr = (ref_wr(aw_addr) == 0) && !m_awgot && !m_bv;
    e_wr  = !m_wgot && !m_bv;
  end

  always @(posedge clk) begin
    bit an, wn;
    if (rst) begin
      m_rsel <= 0; m_wsel <= 0; m_rv <= 0; m_bv <= 0; m_awgot <= 0; m_wgot <= 0;
    end else begin
      m_rsel <= ref_rd(ar_addr);
      m_wsel <= ref_wr(aw_addr);
      if (ar_valid && e_arr) m_rv <= 1;
      else if (m_rv && r_ready) m_rv <= 0;
      an = m_awgot || (aw_valid && e_awr);
      wn = m_wgot || (ew_valid && e_wr);
      if (an && wn) begin
        m_bv <= 1; m_awgot <= 0; m_wgot <= 0;
      end else begin
        m_awgot <= an; m_wgot <= wn;
        if (m_bv && b_ready) m_bv <= 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R1 rd_sel", 64'(rd_sel), 64'(m_rsel));
      chk("R2 wr_sel", 64'(wr_sel), 64'(m_wsel));
      chk("R6 ar_ready", 64'(ar_ready), 64'(e_arr));
      chk("R7 r_valid", 64'(r_valid), 64'(m_rv));
      if (m_rv) begin
        chk("R7 r_resp", 64'(r_resp), 64'h3);
        chk("R7 r_data", 64'(r_data), 64'h0);
      end
      chk("R9 aw_ready", 64'(aw_ready), 64'(e_awr));
      chk("R9 ew_ready", 64'(ew_ready), 64'(e_wr));
      chk("R8 b_valid", 64'(b_valid), 64'(m_bv));
      if (m_bv) chk("R8 b_resp", 64'(b_resp), 64'h3);
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic probe(input logic [AW-1:0] ra, input logic [AW-1:0] wa,
                       input int er, input int ew, input string tag);
    ar_addr = ra; aw_addr = wa;
    step();
    #1;
    chk({tag, " rd"}, 64'(rd_sel), 64'(er));
    chk({tag, " wr"}, 64'(wr_sel), 64'(ew));
  endtask

  initial begin
    step(3);
    #1;
    chk("R10 r_valid", 64'(r_valid), 0);
    chk("R10 b_valid", 64'(b_valid), 0);
    chk("R10 rd_sel", 64'(rd_sel), 0);
    chk("R10 wr_sel", 64'(wr_sel), 0);
    rst = 0;
    cmp_on = 1;
    step();
    // boundaries and policies
    probe(16'h0000, 16'h0000, 1, 1, "R1 base");
    probe(16'h0FFF, 16'h0FFF, 1, 1, "R2 bound-1");
    probe(16'h1000, 16'h1000, 2, 0, "R3 read-only");
    probe(16'h1FFF, 16'h2000, 2, 3, "R3 edge");
    probe(16'h2000, 16'h2FFF, 0, 3, "R3 write-only");
    probe(16'h3000, 16'h3000, 0, 0, "R4 hole");
    probe(16'h7FFF, 16'hFFFF, 0, 0, "R4 hole hi");
    probe(16'h8000, 16'h8FFF, 1, 1, "R5 disjoint");
    probe(16'h9000, 16'h0800, 0, 1, "R5 bound");
    // read error with stalled ready
    ar_addr = 16'h4000; ar_valid = 1; step(); ar_valid = 0;
    #1; chk("R7 rise", 64'(r_valid), 1);
    step(3); #1; chk("R7 held", 64'(r_valid), 1);
    r_ready = 1; step(); r_ready = 0; #1; chk("R7 drop", 64'(r_valid), 0);
    // write: AW first
    aw_addr = 16'h5000; aw_valid = 1; step(); aw_valid = 0;
    step(2); #1; chk("R8 aw only", 64'(b_valid), 0);
    ew_valid = 1; step(); ew_valid = 0; #1; chk("R8 after w", 64'(b_valid), 1);
    step(2); b_ready = 1; step(); b_ready = 0;
    // W first
    ew_valid = 1; step(); ew_valid = 0; step(2);
    #1; chk("R9 w taken", 64'(ew_ready), 0);
    aw_valid = 1; step(); aw_valid = 0; #1; chk("R8 after aw", 64'(b_valid), 1);
    b_ready = 1; step(); b_ready = 0;
    // together
    aw_valid = 1; ew_valid = 1; step(); aw_valid = 0; ew_valid = 0;
    #1; chk("R8 pair", 64'(b_valid), 1);
    b_ready = 1; step(); b_ready = 0;
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] pool [8] = '{16'h0000, 16'h1000, 16'h2000, 16'h3000,
                                  16'h8000, 16'h9000, 16'h0FFF, 16'hF000};
      ar_addr  = pool[$urandom_range(7)] + AW'($urandom_range(3));
      aw_addr  = pool[$urandom_range(7)] + AW'($urandom_range(3));
      ar_valid = ($urandom_range(2) == 0);
      aw_valid = ($urandom_range(2) == 0);
      ew_valid = ($urandom_range(2) == 0);
      r_ready  = ($urandom_range(3) == 0);
      b_ready  = ($urandom_range(3) == 0);
      step();
    end
    ar_valid = 0; aw_valid = 0; ew_valid = 0;
    step(2);
    cmp_on = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule